// File: doc/BRIEF.md
# DMA Controller Command, Mask and Status Registers

This block is the control-port front end of a four-channel DMA controller. Software reaches it through eight byte-wide control offsets selected by a 3-bit offset, with separate read and write strobes. Through those offsets it loads a command register, masks or unmasks channels, stores a per-channel mode byte, raises or drops software transfer requests, clears the byte-pointer flip-flop and issues a master reset. Reads return the status byte or the mask.

The status byte holds terminal-count flags in the low nibble, one per channel, and request flags in the high nibble. The request flags are shared by two sources. Software sets them through the request offset, and per-channel hardware lines hold and release them. The transfer engine raises the terminal-count flags with single-cycle pulses. A status read clears those flags. Arbitration and the data movement itself sit in other blocks, which consume the mask, mode, command and status outputs.

Top module: `dmac_ctl`

## Requirements
- R1: A write to offset 0 loads the command register only if the value has no bit set other than bit 2, so only 0x00 and 0x04 are taken. Any other value leaves the command register unchanged.
- R2: A write to offset 1 selects channel c = wdata[1:0]. It sets status bit c+4 to wdata[2] and clears status bit c.
- R3: A write to offset 2 sets mask bit wdata[1:0] when wdata[2] is 1, and clears it when wdata[2] is 0. The other mask bits keep their values.
- R4: A write to offset 3 stores the whole byte as the mode register of channel wdata[1:0]. The fields are: bits 3:2 transfer type, bit 4 auto-init, bit 5 decrement, bits 7:6 operating mode. Channel c occupies mode_q[8c+7:8c]. The mode registers change on no other write.
- R5: A write to offset 4 drives ff_clr high in that same cycle and changes no register.
- R6: A write to offset 5 drives ff_clr high in that cycle. At the next clock edge it sets all mask bits, clears status and clears the command register. This takes priority over every other event in the same cycle.
- R7: A write to offset 6 clears all mask bits. A write to offset 7 loads the mask from wdata[3:0].
- R8: While rd_en is high, rdata is combinational. Offset 0 returns the status, offset 1 returns {4'b0, mask}, and any other offset returns 0. A read of offset 0 clears status bits 3:0 at the next clock edge.
- R9: hreq_hold[c] sets status bit c+4 and hreq_rel[c] clears it. If both arrive in the same cycle, release wins. Both take priority over a same-cycle software request write.
- R10: tc_set[c] sets status bit c. It takes priority over a same-cycle status read and over a same-cycle offset-1 write to channel c.
- R11: After reset the registers hold these values: command 0, mask 4'hF, status 0, all mode registers 0. rdata and ff_clr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_off | input | 3 | Control offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| hreq_hold | input | 4 | Per-channel hardware request assert |
| hreq_rel | input | 4 | Per-channel hardware request release |
| tc_set | input | 4 | Per-channel terminal-count pulse from the transfer engine |
| cmd_q | output | 8 | Command register |
| mask_q | output | 4 | Channel mask, 1 = masked |
| mode_q | output | 32 | Four mode bytes, channel c at bits 8c+7:8c |
| status_q | output | 8 | Request flags 7:4, terminal-count flags 3:0 |
| ff_clr | output | 1 | Byte flip-flop clear pulse |
| rdata | output | 8 | Read data |

## Verification
The decoder is driven with single writes at each of the eight offsets and with reads at used and unused offsets. These patterns separate a wrong offset decode from a wrong field extraction. Command writes use one accepted and one rejected non-zero value, which shows whether the unsupported-bit filter is in place. Deliberate same-cycle collisions test the status priorities: hold against release, hardware lines against a software request write, a terminal-count pulse against a status read and against a request write, and master reset against a pending hardware hold. A wrong priority order shows up as a different status byte.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

   typedef enum logic [2:0] {
      OFF_CMD    = 3'd0,
      OFF_REQ    = 3'd1,
      OFF_MSK1   = 3'd2,
      OFF_MODE   = 3'd3,
      OFF_FFCLR  = 3'd4,
      OFF_MRST   = 3'd5,
      OFF_UNMASK = 3'd6,
      OFF_MSKALL = 3'd7
   } dmac_off_e;

   localparam int unsigned NUM_OFF = 8;

   typedef struct packed {
      logic [NUM_OFF-1:0] wr_hit;
      logic               rd_stat;
      logic               rd_mask;
   } dmac_strobe_t;

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
   import dmac_pkg::*;
#(
   parameter int unsigned NCH = 4,
   parameter int unsigned DW  = 8,
   localparam int unsigned SEL_W = $clog2(NCH)
) (
   input  logic [2:0]    port_off,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [DW-1:0] wdata,
   output dmac_strobe_t  stb,
   output logic [NCH-1:0] ch_sel,
   output logic          set_bit
);

   for (genvar o = 0; o < NUM_OFF; o++) begin : g_hit
      assign stb.wr_hit[o] = wr_en && (port_off == 3'(o));
   end

   assign stb.rd_stat = rd_en && (port_off == OFF_CMD);
   assign stb.rd_mask = rd_en && (port_off == OFF_REQ);

   for (genvar c = 0; c < NCH; c++) begin : g_sel
      assign ch_sel[c] = (wdata[SEL_W-1:0] == SEL_W'(c));
   end

   assign set_bit = wdata[2];

endmodule

// File: rtl/dmac_mask.sv
module dmac_mask #(
   parameter int unsigned NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mrst,
   input  logic           one_wr,
   input  logic           all_clr,
   input  logic           all_ld,
   input  logic [NCH-1:0] ch_sel,
   input  logic           set_bit,
   input  logic [NCH-1:0] ld_val,
   output logic [NCH-1:0] mask_q
);

   for (genvar c = 0; c < NCH; c++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[c] <= 1'b1;
         end else if (mrst) begin
            mask_q[c] <= 1'b1;
         end else if (all_clr) begin
            mask_q[c] <= 1'b0;
         end else if (all_ld) begin
            mask_q[c] <= ld_val[c];
         end else if (one_wr && ch_sel[c]) begin
            mask_q[c] <= set_bit;
         end
      end
   end

endmodule

// File: rtl/dmac_status.sv
module dmac_status #(
   parameter int unsigned NCH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mrst,
   input  logic             req_wr,
   input  logic             rd_stat,
   input  logic [NCH-1:0]   ch_sel,
   input  logic             set_bit,
   input  logic [NCH-1:0]   hold,
   input  logic [NCH-1:0]   rel,
   input  logic [NCH-1:0]   tc,
   output logic [2*NCH-1:0] status_q
);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      // request flag: release, then hold, then software write
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            status_q[NCH+c] <= 1'b0;
         end else if (mrst) begin
            status_q[NCH+c] <= 1'b0;
         end else if (rel[c]) begin
            status_q[NCH+c] <= 1'b0;
         end else if (hold[c]) begin
            status_q[NCH+c] <= 1'b1;
         end else if (req_wr && ch_sel[c]) begin
            status_q[NCH+c] <= set_bit;
         end
      end

      // terminal-count flag: a new pulse beats both clear sources
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            status_q[c] <= 1'b0;
         end else if (mrst) begin
            status_q[c] <= 1'b0;
         end else if (tc[c]) begin
            status_q[c] <= 1'b1;
         end else if (rd_stat) begin
            status_q[c] <= 1'b0;
         end else if (req_wr && ch_sel[c]) begin
            status_q[c] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl
   import dmac_pkg::*;
#(
   parameter int unsigned NCH        = 4,
   parameter int unsigned DW         = 8,
   parameter bit          CMD_FILTER = 1'b1,
   parameter logic [7:0]  CMD_OK     = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        port_off,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DW-1:0]     wdata,
   input  logic [NCH-1:0]    hreq_hold,
   input  logic [NCH-1:0]    hreq_rel,
   input  logic [NCH-1:0]    tc_set,
   output logic [DW-1:0]     cmd_q,
   output logic [NCH-1:0]    mask_q,
   output logic [NCH*DW-1:0] mode_q,
   output logic [2*NCH-1:0]  status_q,
   output logic              ff_clr,
   output logic [DW-1:0]     rdata
);

   if (DW != 2 * NCH) begin : g_bad_width
      $error("dmac_ctl: status must hold two flags per channel in one data word");
   end
   if (NCH != (1 << $clog2(NCH)) || NCH < 2) begin : g_bad_nch
      $error("dmac_ctl: channel count must be a power of two, at least 2");
   end
   if (DW < 3) begin : g_bad_dw
      $error("dmac_ctl: data width too small for channel and set fields");
   end

   dmac_strobe_t   stb;
   logic [NCH-1:0] ch_sel;
   logic           set_bit;
   logic           cmd_take;

   dmac_decode #(.NCH(NCH), .DW(DW)) u_dec (
      .port_off (port_off),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .wdata    (wdata),
      .stb      (stb),
      .ch_sel   (ch_sel),
      .set_bit  (set_bit)
   );

   dmac_mask #(.NCH(NCH)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .mrst    (stb.wr_hit[OFF_MRST]),
      .one_wr  (stb.wr_hit[OFF_MSK1]),
      .all_clr (stb.wr_hit[OFF_UNMASK]),
      .all_ld  (stb.wr_hit[OFF_MSKALL]),
      .ch_sel  (ch_sel),
      .set_bit (set_bit),
      .ld_val  (wdata[NCH-1:0]),
      .mask_q  (mask_q)
   );

   dmac_status #(.NCH(NCH)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .mrst     (stb.wr_hit[OFF_MRST]),
      .req_wr   (stb.wr_hit[OFF_REQ]),
      .rd_stat  (stb.rd_stat),
      .ch_sel   (ch_sel),
      .set_bit  (set_bit),
      .hold     (hreq_hold),
      .rel      (hreq_rel),
      .tc       (tc_set),
      .status_q (status_q)
   );

   // command filter variant
   if (CMD_FILTER) begin : g_cmd_filt
      assign cmd_take = ((wdata & ~DW'(CMD_OK)) == '0);
   end else begin : g_cmd_open
      assign cmd_take = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= '0;
      end else if (stb.wr_hit[OFF_MRST]) begin
         cmd_q <= '0;
      end else if (stb.wr_hit[OFF_CMD] && cmd_take) begin
         cmd_q <= wdata;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_mode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mode_q[c*DW +: DW] <= '0;
         end else if (stb.wr_hit[OFF_MODE] && ch_sel[c]) begin
            mode_q[c*DW +: DW] <= wdata;
         end
      end
   end

   assign ff_clr = stb.wr_hit[OFF_FFCLR] | stb.wr_hit[OFF_MRST];

   always_comb begin
      rdata = '0;
      if (stb.rd_stat) begin
         rdata = status_q;
      end else if (stb.rd_mask) begin
         rdata = DW'(mask_q);
      end
   end

endmodule

// File: rtl/dmac_ctl_chk.sv
module dmac_ctl_chk #(
   parameter int unsigned NCH    = 4,
   parameter int unsigned DW     = 8,
   parameter logic [7:0]  CMD_OK = 8'h04
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        port_off,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DW-1:0]     wdata,
   input logic [NCH-1:0]    hreq_hold,
   input logic [NCH-1:0]    hreq_rel,
   input logic [NCH-1:0]    tc_set,
   input logic [DW-1:0]     cmd_q,
   input logic [NCH-1:0]    mask_q,
   input logic [NCH*DW-1:0] mode_q,
   input logic [2*NCH-1:0]  status_q,
   input logic              ff_clr,
   input logic [DW-1:0]     rdata
);

   logic mrst_w;
   assign mrst_w = wr_en && (port_off == 3'd5);

   p_cmd_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_off == 3'd0 && (wdata & ~DW'(CMD_OK)) != '0 && !mrst_w)
      |=> $stable(cmd_q));

   p_mode_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && port_off == 3'd3) |=> $stable(mode_q));

   p_ffclr_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ff_clr |-> wr_en);

   p_mrst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mrst_w |=> (mask_q == '1 && status_q == '0 && cmd_q == '0));

   p_rdclr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && port_off == 3'd0 && !wr_en && tc_set == '0)
      |=> status_q[NCH-1:0] == '0);

   p_rd_other_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && port_off > 3'd1) |-> rdata == '0);

   p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hreq_rel != '0 && !mrst_w)
      |=> (status_q[2*NCH-1:NCH] & $past(hreq_rel)) == '0);

   p_tc_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (tc_set != '0 && !mrst_w)
      |=> (status_q[NCH-1:0] & $past(tc_set)) == $past(tc_set));

endmodule

bind dmac_ctl dmac_ctl_chk #(.NCH(NCH), .DW(DW), .CMD_OK(CMD_OK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .port_off  (port_off),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .wdata     (wdata),
   .hreq_hold (hreq_hold),
   .hreq_rel  (hreq_rel),
   .tc_set    (tc_set),
   .cmd_q     (cmd_q),
   .mask_q    (mask_q),
   .mode_q    (mode_q),
   .status_q  (status_q),
   .ff_clr    (ff_clr),
   .rdata     (rdata)
);

// File: tb/test_dmac_ctl.sv
`timescale 1ns/1ps
module test_dmac_ctl;

   localparam int NCH = 4;
   localparam int DW  = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [2:0]      port_off = '0;
   logic            wr_en = 1'b0;
   logic            rd_en = 1'b0;
   logic [7:0]      wdata = '0;
   logic [3:0]      hreq_hold = '0;
   logic [3:0]      hreq_rel = '0;
   logic [3:0]      tc_set = '0;
   logic [7:0]      cmd_q;
   logic [3:0]      mask_q;
   logic [31:0]     mode_q;
   logic [7:0]      status_q;
   logic            ff_clr;
   logic [7:0]      rdata;

   always #2 clk = ~clk;

   dmac_ctl i_dmac_ctl (
      .clk(clk), .rst_n(rst_n), .port_off(port_off), .wr_en(wr_en),
      .rd_en(rd_en), .wdata(wdata), .hreq_hold(hreq_hold),
      .hreq_rel(hreq_rel), .tc_set(tc_set), .cmd_q(cmd_q),
      .mask_q(mask_q), .mode_q(mode_q), .status_q(status_q),
      .ff_clr(ff_clr), .rdata(rdata)
   );

   typedef enum int {K_CMD, K_MASK, K_STAT, K_MODE, K_RD, K_FF} kind_e;
   typedef struct {
      kind_e       kind;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t q_comb[$];
   item_t q_reg[$];
   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 1'b0;

   // expected state from the requirements
   logic [7:0]  e_cmd = '0;
   logic [3:0]  e_mask = 4'hF;
   logic [7:0]  e_stat = '0;
   logic [31:0] e_mode = '0;

   function automatic logic [31:0] actual(kind_e k);
      case (k)
         K_CMD:  return {24'b0, cmd_q};
         K_MASK: return {28'b0, mask_q};
         K_STAT: return {24'b0, status_q};
         K_MODE: return mode_q;
         K_RD:   return {24'b0, rdata};
         default: return {31'b0, ff_clr};
      endcase
   endfunction

   task automatic compare(item_t it);
      logic [31:0] a;
      a = actual(it.kind);
      n_run++;
      if (a !== it.exp) begin
         n_fail++;
         $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, a, it.exp);
      end
   endtask

   // monitors
   initial forever begin
      @(negedge clk); #1;
      while (q_comb.size() > 0) compare(q_comb.pop_front());
   end
   initial forever begin
      @(posedge clk); #1;
      while (q_reg.size() > 0) compare(q_reg.pop_front());
   end

   task automatic push_state(string req);
      q_reg.push_back('{K_CMD,  {24'b0, e_cmd},  req});
      q_reg.push_back('{K_MASK, {28'b0, e_mask}, req});
      q_reg.push_back('{K_STAT, {24'b0, e_stat}, req});
      q_reg.push_back('{K_MODE, e_mode,          req});
   endtask

   // driver: one cycle of stimulus, expectations derived from R1..R11
   task automatic op(input logic [2:0] off, input bit wr, input bit rd,
                     input logic [7:0] wd, input logic [3:0] hold,
                     input logic [3:0] rel, input logic [3:0] tc,
                     input string req);
      logic [7:0] x_rd;
      int c;
      bit mrst;
      @(negedge clk);
      port_off = off; wr_en = wr; rd_en = rd; wdata = wd;
      hreq_hold = hold; hreq_rel = rel; tc_set = tc;
      x_rd = 8'h00;
      if (rd && off == 3'd0) x_rd = e_stat;
      if (rd && off == 3'd1) x_rd = {4'b0, e_mask};
      q_comb.push_back('{K_RD, {24'b0, x_rd}, req});
      q_comb.push_back('{K_FF, {31'b0, (wr && (off == 3'd4 || off == 3'd5))}, req});
      c = int'(wd[1:0]);
      mrst = wr && off == 3'd5;
      if (wr) begin
         case (off)
            3'd0: if ((wd & 8'hFB) == 8'h00) e_cmd = wd;
            3'd1: begin e_stat[c+4] = wd[2]; e_stat[c] = 1'b0; end
            3'd2: e_mask[c] = wd[2];
            3'd3: e_mode[c*8 +: 8] = wd;
            3'd5: begin e_mask = 4'hF; e_stat = '0; e_cmd = '0; end
            3'd6: e_mask = 4'h0;
            3'd7: e_mask = wd[3:0];
            default: ;
         endcase
      end
      if (rd && off == 3'd0 && !mrst) e_stat[3:0] = 4'h0;
      if (!mrst) begin
         for (int i = 0; i < 4; i++) begin
            if (hold[i]) e_stat[i+4] = 1'b1;
            if (rel[i])  e_stat[i+4] = 1'b0;
            if (tc[i])   e_stat[i]   = 1'b1;
         end
      end
      push_state(req);
   endtask

   task automatic idle();
      @(negedge clk);
      port_off = '0; wr_en = 0; rd_en = 0; wdata = '0;
      hreq_hold = '0; hreq_rel = '0; tc_set = '0;
   endtask

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11 reset state
      q_comb.push_back('{K_RD, 32'h0, "R11"});
      q_comb.push_back('{K_FF, 32'h0, "R11"});
      push_state("R11");
      rst_n = 1'b1;

      // R1 command filter
      op(3'd0, 1, 0, 8'h04, 4'h0, 4'h0, 4'h0, "R1 accept 0x04");
      op(3'd0, 1, 0, 8'h01, 4'h0, 4'h0, 4'h0, "R1 reject 0x01");
      op(3'd0, 1, 0, 8'h24, 4'h0, 4'h0, 4'h0, "R1 reject 0x24");
      op(3'd0, 1, 0, 8'h00, 4'h0, 4'h0, 4'h0, "R1 accept 0x00");
      // R4 mode bytes
      op(3'd3, 1, 0, 8'h58, 4'h0, 4'h0, 4'h0, "R4 ch0");
      op(3'd3, 1, 0, 8'h95, 4'h0, 4'h0, 4'h0, "R4 ch1");
      op(3'd3, 1, 0, 8'h5A, 4'h0, 4'h0, 4'h0, "R4 ch2");
      op(3'd3, 1, 0, 8'hE7, 4'h0, 4'h0, 4'h0, "R4 ch3");
      op(3'd3, 1, 0, 8'h29, 4'h0, 4'h0, 4'h0, "R4 ch1 rewrite");
      // R7 / R3 masks
      op(3'd6, 1, 0, 8'h00, 4'h0, 4'h0, 4'h0, "R7 unmask all");
      op(3'd2, 1, 0, 8'h06, 4'h0, 4'h0, 4'h0, "R3 set ch2");
      op(3'd2, 1, 0, 8'h07, 4'h0, 4'h0, 4'h0, "R3 set ch3");
      op(3'd2, 1, 0, 8'h02, 4'h0, 4'h0, 4'h0, "R3 clear ch2");
      op(3'd7, 1, 0, 8'hFA, 4'h0, 4'h0, 4'h0, "R7 load 0xA");
      op(3'd1, 0, 1, 8'h00, 4'h0, 4'h0, 4'h0, "R8 read mask");
      // R2 / R9 requests
      op(3'd1, 1, 0, 8'h05, 4'h0, 4'h0, 4'h0, "R2 sw req ch1");
      op(3'd0, 0, 0, 8'h00, 4'h8, 4'h0, 4'h0, "R9 hold ch3");
      op(3'd0, 0, 0, 8'h00, 4'h1, 4'h1, 4'h0, "R9 hold+rel ch0");
      op(3'd1, 1, 0, 8'h04, 4'h0, 4'h1, 4'h0, "R9 rel beats sw set");
      op(3'd1, 1, 0, 8'h03, 4'h8, 4'h0, 4'h0, "R9 hold beats sw clear");
      op(3'd0, 0, 0, 8'h00, 4'h0, 4'h8, 4'h0, "R9 release ch3");
      // R10 / R8 terminal count
      op(3'd0, 0, 0, 8'h00, 4'h0, 4'h0, 4'h4, "R10 tc ch2");
      op(3'd0, 0, 0, 8'h00, 4'h0, 4'h0, 4'h1, "R10 tc ch0");
      op(3'd0, 0, 1, 8'h00, 4'h0, 4'h0, 4'h0, "R8 status read clears tc");
      op(3'd0, 0, 1, 8'h00, 4'h0, 4'h0, 4'h2, "R10 tc beats read");
      op(3'd0, 0, 1, 8'h00, 4'h0, 4'h0, 4'h0, "R8 read after tc");
      op(3'd0, 0, 0, 8'h00, 4'h0, 4'h0, 4'h8, "R10 tc ch3");
      op(3'd1, 1, 0, 8'h07, 4'h0, 4'h0, 4'h0, "R2 sw write clears tc ch3");
      op(3'd1, 1, 0, 8'h00, 4'h0, 4'h0, 4'h1, "R10 tc beats sw clear");
      op(3'd3, 0, 1, 8'h00, 4'h0, 4'h0, 4'h0, "R8 read off3 zero");
      op(3'd7, 0, 1, 8'h00, 4'h0, 4'h0, 4'h0, "R8 read off7 zero");
      // R5 flip-flop clear
      op(3'd4, 1, 0, 8'hFF, 4'h0, 4'h0, 4'h0, "R5 ff clear only");
      // R6 master reset
      op(3'd0, 1, 0, 8'h04, 4'h4, 4'h0, 4'h0, "R1 cmd before mrst");
      op(3'd5, 1, 0, 8'h00, 4'h2, 4'h0, 4'h8, "R6 master reset");
      op(3'd0, 0, 1, 8'h00, 4'h0, 4'h0, 4'h0, "R6 status after mrst");
      idle();
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule